// File: doc/BRIEF.md
# Arithmetic Fault Trap Detector

This block sits beside a processor's arithmetic unit and turns four kinds of arithmetic fault into one trap request. It looks at a divide as the divide starts. It looks at the upper part of every result written to either of the two 40-bit accumulators. It also looks at the count of every shift. The block does no arithmetic itself. It takes strobes and operand summaries from the datapath, and it reports faults through a one-cycle trap pulse and a set of sticky cause bits.

A zero divisor is reported in the same cycle that the divide starts, on `div_abort`. The divider uses this to abandon the operation at the next cycle boundary instead of producing a quotient. The two accumulator overflow checks depend on mode bits. An overflow out of bit 31 counts as a fault only while its trap is enabled and the guard bits are not in use. A catastrophic overflow out of bit 39 counts only while its trap is enabled and saturation for that accumulator is off. A trap handler reads `cause` to see what happened and clears the bits it has handled with `cause_clr`.

Every interface here is a single-cycle strobe with its data. None of the inputs or outputs carries a stream, so there is no valid/ready handshake and no back-pressure. The datapath never waits on this block.

Top module: `math_fault_trap`

## Requirements
- R1: After reset, `cause` is all zero and `trap_req` and `div_abort` are low.
- R2: `div_abort` is high in the same cycle as `div_go` exactly when `div_go` is high and `divisor` is zero. A nonzero divisor never raises it.
- R3: A zero-divisor start sets `cause[0]` at the next clock edge.
- R4: An accumulator write whose bits 39..31 are not all equal sets the bit-31 overflow cause at the next edge, but only while `ovf_lo_en` is 1 and `guard_on` is 0. The cause is `cause[1]` for accumulator A and `cause[2]` for B.
- R5: An accumulator write sets the catastrophic-overflow cause at the next edge when all of these hold:
  - `ovf_hi_en` is 1.
  - That accumulator's `sat_on` bit is 0.
  - Both operand signs are equal.
  - Result bit 39 differs from the operand signs.

  The cause is `cause[3]` for A and `cause[4]` for B.
- R6: A shift with `shift_go` high whose two's-complement `shift_cnt` has a magnitude above 16 sets `cause[5]` at the next edge. Counts from -16 to +16 do not.
- R7: `trap_req` is high for one cycle, at the edge after an event, when at least one cause bit goes from 0 to 1. An event whose cause bit is already set raises no trap.
- R8: Cause bits are sticky. A 1 in `cause_clr` clears the matching bit at the next edge. A new event on the same bit in the same cycle wins over the clear.
- R9: Accumulator A and accumulator B faults set separate cause bits and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_go | input | 1 | Divide starts this cycle |
| divisor | input | 16 | Divisor of the starting divide |
| acc_we | input | 2 | Result write strobe, bit 0 = A, bit 1 = B |
| acc_a_hi | input | 9 | Bits 39..31 of the result written to A |
| acc_b_hi | input | 9 | Bits 39..31 of the result written to B |
| opx_sign | input | 2 | Sign of the first operand, per accumulator |
| opy_sign | input | 2 | Sign of the second operand, per accumulator |
| ovf_lo_en | input | 1 | Enable for the bit-31 overflow trap |
| ovf_hi_en | input | 1 | Enable for the catastrophic overflow trap |
| guard_on | input | 1 | Guard bits are in use |
| sat_on | input | 2 | Saturation on, per accumulator |
| shift_go | input | 1 | Shift executes this cycle |
| shift_cnt | input | 6 | Signed shift count |
| cause_clr | input | 6 | Per-bit clear of the sticky causes |
| trap_req | output | 1 | One-cycle math trap request |
| div_abort | output | 1 | Abort the starting divide |
| cause | output | 6 | Sticky causes: 0 div-zero, 1/2 A/B bit-31, 3/4 A/B bit-39, 5 shift |

## Verification
Each detector feeds only its own cause flop, so a wrong detector shows as a wrong `cause` bit one edge after the stimulus. When that bit should have been newly set, it also shows as a missing or extra `trap_req` at the same edge. A corrupted sticky register shows up later. It appears as a bit that drops without a clear, or as a repeated event that wrongly raises a new trap. The divide abort is combinational, so an error there is visible in the same cycle as `div_go`.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int ACC_W   = 40;
  localparam int LO_MSB  = 31;
  localparam int HI_W    = ACC_W - LO_MSB;
  localparam int N_ACC   = 2;
  localparam int N_CAUSE = 2 * N_ACC + 2;
  localparam int C_DIV   = 0;
  localparam int C_LO0   = 1;
  localparam int C_HI0   = 1 + N_ACC;
  localparam int C_SHF   = 1 + 2 * N_ACC;
endpackage

// File: rtl/mft_div_check.sv
module mft_div_check #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] divisor,
  output logic             fault
);
  assign fault = go && (divisor == '0);

  assert_abort_only_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!go || (|divisor)) |-> !fault);
endmodule

// File: rtl/mft_acc_check.sv
module mft_acc_check #(
  parameter int HI_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [HI_W-1:0] res_hi,
  input  logic            sx,
  input  logic            sy,
  input  logic            lo_en,
  input  logic            hi_en,
  input  logic            guard_on,
  input  logic            sat_on,
  output logic            lo_fault,
  output logic            hi_fault
);
  logic spread;
  assign spread   = !((&res_hi) || !(|res_hi));
  assign lo_fault = we && lo_en && !guard_on && spread;
  assign hi_fault = we && hi_en && !sat_on && (sx == sy) && (res_hi[HI_W-1] != sx);

  assert_lo_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lo_en && !guard_on && (res_hi[HI_W-1] != res_hi[0])) |-> lo_fault);
  assert_hi_pos_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hi_en && !sat_on && !sx && !sy && res_hi[HI_W-1]) |-> hi_fault);
endmodule

// File: rtl/mft_shift_check.sv
module mft_shift_check #(
  parameter int SH_W   = 6,
  parameter int SH_MAX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [SH_W-1:0] cnt,
  output logic            fault
);
  localparam int MAG_W = SH_W + 1;
  logic [MAG_W-1:0] ext, mag;
  assign ext   = {cnt[SH_W-1], cnt};
  assign mag   = cnt[SH_W-1] ? (~ext + 1'b1) : ext;
  assign fault = go && (mag > MAG_W'(SH_MAX));

  assert_legal_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ($signed(cnt) >= -SH_MAX) && ($signed(cnt) <= SH_MAX)) |-> !fault);
endmodule

// File: rtl/math_fault_trap.sv
module math_fault_trap
  import mft_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int SH_W   = 6,
  parameter int SH_MAX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_go,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [N_ACC-1:0]   acc_we,
  input  logic [HI_W-1:0]    acc_a_hi,
  input  logic [HI_W-1:0]    acc_b_hi,
  input  logic [N_ACC-1:0]   opx_sign,
  input  logic [N_ACC-1:0]   opy_sign,
  input  logic               ovf_lo_en,
  input  logic               ovf_hi_en,
  input  logic               guard_on,
  input  logic [N_ACC-1:0]   sat_on,
  input  logic               shift_go,
  input  logic [SH_W-1:0]    shift_cnt,
  input  logic [N_CAUSE-1:0] cause_clr,
  output logic               trap_req,
  output logic               div_abort,
  output logic [N_CAUSE-1:0] cause
);
  logic [N_CAUSE-1:0] hit, fresh, cause_q;
  logic               trap_q;
  logic [HI_W-1:0]    hi_sel [N_ACC];

  assign hi_sel[0] = acc_a_hi;
  assign hi_sel[1] = acc_b_hi;

  mft_div_check #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .divisor(divisor), .fault(hit[C_DIV]));

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    mft_acc_check #(.HI_W(HI_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .we(acc_we[i]), .res_hi(hi_sel[i]),
      .sx(opx_sign[i]), .sy(opy_sign[i]), .lo_en(ovf_lo_en), .hi_en(ovf_hi_en),
      .guard_on(guard_on), .sat_on(sat_on[i]),
      .lo_fault(hit[C_LO0+i]), .hi_fault(hit[C_HI0+i]));
  end

  mft_shift_check #(.SH_W(SH_W), .SH_MAX(SH_MAX)) u_shf (
    .clk(clk), .rst_n(rst_n), .go(shift_go), .cnt(shift_cnt), .fault(hit[C_SHF]));

  assign fresh = hit & ~cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      trap_q  <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~cause_clr) | hit;
      trap_q  <= |fresh;
    end
  end

  assign cause     = cause_q;
  assign trap_req  = trap_q;
  assign div_abort = hit[C_DIV];

  assert_abort_records_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_abort |=> cause[C_DIV]);
  assert_trap_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (cause != '0));
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & $past(cause & ~cause_clr)) == $past(cause & ~cause_clr)));
endmodule

// File: tb/tb_math_fault_trap.sv
module tb_math_fault_trap;
  logic       clk = 0, rst_n = 0;
  logic       div_go; logic [15:0] divisor;
  logic [1:0] acc_we; logic [8:0] acc_a_hi, acc_b_hi;
  logic [1:0] opx_sign, opy_sign, sat_on;
  logic       ovf_lo_en, ovf_hi_en, guard_on, shift_go;
  logic [5:0] shift_cnt, cause_clr, cause;
  logic       trap_req, div_abort;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  math_fault_trap dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    div_go = 0; divisor = 16'h1; acc_we = 0; acc_a_hi = 0; acc_b_hi = 0;
    opx_sign = 0; opy_sign = 0; shift_go = 0; shift_cnt = 0; cause_clr = 0;
  endtask

  // pass one edge with current stimulus, then go idle and check outputs
  task automatic step(input logic [5:0] ec, input logic et, input string tag);
    @(negedge clk); idle();
    chk(cause == ec, {tag, " cause"}, cause, ec);
    chk(trap_req == et, {tag, " trap"}, trap_req, et);
  endtask

  task automatic clear_all();
    @(negedge clk); cause_clr = 6'h3f;
    step(6'h00, 0, "R8 clear");
  endtask

  task automatic t_reset();
    chk(cause == 0, "R1 cause", cause, 0);
    chk(trap_req == 0, "R1 trap", trap_req, 0);
    chk(div_abort == 0, "R1 abort", div_abort, 0);
  endtask

  task automatic t_div();
    @(negedge clk); div_go = 1; divisor = 16'h0005; #1;
    chk(div_abort == 0, "R2 nonzero", div_abort, 0);
    step(6'h00, 0, "R2 nonzero");
    @(negedge clk); div_go = 1; divisor = 0; #1;
    chk(div_abort == 1, "R2 zero", div_abort, 1);
    step(6'h01, 1, "R3 divzero");
    chk(trap_req == 1, "R7 pulse", trap_req, 1);
    @(negedge clk);
    chk(trap_req == 0, "R7 one cycle", trap_req, 0);
    chk(cause == 6'h01, "R8 sticky", cause, 1);
    div_go = 1; divisor = 0;
    step(6'h01, 0, "R7 no retrap");
    clear_all();
  endtask

  task automatic t_lo();
    ovf_lo_en = 1; guard_on = 0;
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h001;
    step(6'h02, 1, "R4 A lo");
    clear_all();
    @(negedge clk); acc_we = 2'b10; acc_b_hi = 9'h1fe;
    step(6'h04, 1, "R9 B lo");
    clear_all();
    @(negedge clk); acc_we = 2'b11; acc_a_hi = 9'h1ff; acc_b_hi = 9'h000;
    step(6'h00, 0, "R4 all equal");
    guard_on = 1;
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h001;
    step(6'h00, 0, "R4 guard masks");
    guard_on = 0; ovf_lo_en = 0;
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h001;
    step(6'h00, 0, "R4 disabled");
  endtask

  task automatic t_hi();
    ovf_hi_en = 1; sat_on = 0;
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h100; opx_sign = 0; opy_sign = 0;
    step(6'h08, 1, "R5 A pos wrap");
    clear_all();
    @(negedge clk); acc_we = 2'b10; acc_b_hi = 9'h0ff; opx_sign = 2'b10; opy_sign = 2'b10;
    step(6'h10, 1, "R9 B neg wrap");
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h100; opx_sign = 2'b01; opy_sign = 2'b00;
    step(6'h10, 0, "R5 mixed signs");
    clear_all();
    sat_on = 2'b01;
    @(negedge clk); acc_we = 2'b01; acc_a_hi = 9'h100;
    step(6'h00, 0, "R5 sat masks");
    sat_on = 0; ovf_hi_en = 0;
  endtask

  task automatic t_shift();
    @(negedge clk); shift_go = 1; shift_cnt = 6'd16;
    step(6'h00, 0, "R6 +16 ok");
    @(negedge clk); shift_go = 1; shift_cnt = 6'h30; // -16
    step(6'h00, 0, "R6 -16 ok");
    @(negedge clk); shift_go = 1; shift_cnt = 6'd17;
    step(6'h20, 1, "R6 +17");
    clear_all();
    @(negedge clk); shift_go = 1; shift_cnt = 6'h20; // -32
    step(6'h20, 1, "R6 -32");
    clear_all();
    @(negedge clk); shift_go = 0; shift_cnt = 6'd31;
    step(6'h00, 0, "R6 no strobe");
  endtask

  task automatic t_clear_race();
    @(negedge clk); div_go = 1; divisor = 0;
    step(6'h01, 1, "R8 set");
    @(negedge clk); div_go = 1; divisor = 0; cause_clr = 6'h01;
    step(6'h01, 0, "R8 set wins");
    @(negedge clk); shift_go = 1; shift_cnt = 6'd20; cause_clr = 6'h20;
    step(6'h21, 1, "R8 partial");
    @(negedge clk); cause_clr = 6'h01;
    step(6'h20, 0, "R8 one bit clr");
    clear_all();
  endtask

  initial begin
    idle(); ovf_lo_en = 0; ovf_hi_en = 0; guard_on = 0; sat_on = 0;
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); t_reset();
    t_div(); t_lo(); t_hi(); t_shift(); t_clear_race();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule